// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block sits in front of the sector buffer of a page-programmed nonvolatile array. It watches every byte-load event on its input stream. It recognises fixed unlock sequences hidden among ordinary page loads, and it owns a write-protect flag that survives from one page write to the next. For each page it decides whether the loads may reach the sector buffer. It reports when a page is ready for the program cycle. It can also start a self-timed clear of the whole array.

Loads arrive on a valid/ready stream. A load is consumed on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` drops while a program cycle is pending and while a chip clear runs, and in the one cycle where a byte-load window expires. A producer must hold its load until it is consumed. Accepted page bytes leave on a registered store strobe that carries the latched sector and the byte index. Protect-flag changes wait for the end-of-program indication from the sector controller.

A command is a chain of loads. Each link needs a set address (`5555h` or `2AAAh`) and a set data byte. The first link of every command is `AAh` written at `5555h`. A load that matches this first link while no page is open is always taken as the start of a command.

Top module: `wprot_seq`

## Requirements
- R1: After reset the protect flag is 0, `ld_ready` is 1, and `page_open`, `clr_busy` and all event pulses are 0.
- R2: With protection off, a load that opens a page is stored. Each accepted page load gives one `buf_we` pulse in the cycle after it is consumed. `buf_addr` is {address bits 14:7 of the page's first load, bits 6:0 of the current load}, and `buf_data` is the loaded byte. After `PAGE_BYTES` loads, `page_go` pulses once.
- R3: The loads AAh@5555h, 55h@2AAAh, A0h@5555h are not stored. They open a page. When that page completes and `prog_done` arrives, the protect flag becomes 1.
- R4: The loads AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h are not stored. They open a page. When that page completes and `prog_done` arrives, the protect flag becomes 0.
- R5: The protect flag changes only on the clock edge where `prog_done` is high while a program cycle is pending.
- R6: With protection on, a load that does not begin a command pulses `wr_reject` for one cycle, stores nothing and opens no page. A page with the enable prefix is accepted, and the flag stays 1.
- R7: A command load with the wrong address or data pulses `seq_abort` for one cycle. The sequencer returns to idle, and the load is not stored.
- R8: If more than `WIN_CYC` cycles pass between loads inside a command, the sequencer pulses `seq_abort` and returns to idle.
- R9: If the window expires on an unprotected page that has at least one byte, `page_go` pulses and the partial page goes to programming.
- R10: If the window expires after an enable or disable command before all `PAGE_BYTES` bytes are loaded, `seq_abort` pulses, no `page_go` follows, and the flag is unchanged.
- R11: The loads AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h pulse `clr_start`. `clr_busy` is then high for `CLR_CYC` cycles with `ld_ready` low, and the protect flag is unchanged.
- R12: After `page_go`, `ld_ready` stays low until `prog_done`. A load offered while `ld_ready` is low is not consumed and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load event valid |
| ld_ready | output | 1 | Sequencer can consume a load |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | 8 | Load data byte |
| prog_done | input | 1 | End-of-program pulse from the sector controller |
| buf_we | output | 1 | Store strobe toward the sector buffer |
| buf_addr | output | ADDR_W | Latched sector and byte index of the store |
| buf_data | output | 8 | Byte to store |
| page_open | output | 1 | A page write is permitted and collecting bytes |
| page_go | output | 1 | Pulse: page ready for its program cycle |
| prot_on | output | 1 | Write-protect flag |
| clr_start | output | 1 | Pulse: start the whole-array clear |
| clr_busy | output | 1 | Array clear timer running |
| seq_abort | output | 1 | Pulse: command or page aborted |
| wr_reject | output | 1 | Pulse: unprefixed write refused under protection |

## Verification
The bench runs randomised unprotected pages. In these pages the byte order is a permutation and the upper address bits change on every load. This shows whether the sector is latched from the first load only, separately from the byte index. Directed enable, disable and clear chains are compared with near-miss chains (a wrong final data byte, a wrong address in step two). This separates full decoding from prefix matching. Window expiry is tried in three settings: inside a command, after an enable with no data or a partial page, and on a plain partial page. These tell the abort path apart from the partial-program path. Flag sampling before and after `prog_done` shows that protection changes only when the program cycle ends.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ,
    ST_PAGE,
    ST_PROG,
    ST_CLR
  } seq_st_e;

  typedef enum logic [1:0] {
    PD_NONE,
    PD_EN,
    PD_DIS
  } pend_e;

  localparam logic [15:0] KEY_ADR_P = 16'h5555;
  localparam logic [15:0] KEY_ADR_Q = 16'h2AAA;
  localparam logic [7:0]  KEY_LEAD  = 8'hAA;
  localparam logic [7:0]  KEY_SECND = 8'h55;
  localparam logic [7:0]  KEY_EN    = 8'hA0;
  localparam logic [7:0]  KEY_EXT   = 8'h80;
  localparam logic [7:0]  KEY_DIS   = 8'h20;
  localparam logic [7:0]  KEY_CLR   = 8'h10;
endpackage

// File: rtl/wprot_match.sv
module wprot_match
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              m_cont,
  output logic              m_en,
  output logic              m_dis,
  output logic              m_clr
);
  logic [ADDR_W-1:0] exp_a;
  logic [7:0]        exp_d;
  logic              a_ok;

  always_comb begin
    exp_a = KEY_ADR_P[ADDR_W-1:0];
    exp_d = KEY_LEAD;
    case (step)
      3'd1: begin exp_a = KEY_ADR_Q[ADDR_W-1:0]; exp_d = KEY_SECND; end
      3'd2: exp_d = KEY_EXT;
      3'd4: begin exp_a = KEY_ADR_Q[ADDR_W-1:0]; exp_d = KEY_SECND; end
      3'd5: exp_d = KEY_DIS;
      default: ;
    endcase
  end

  assign a_ok   = (addr == exp_a);
  assign m_cont = a_ok && (step != 3'd5) && (data == exp_d);
  assign m_en   = a_ok && (step == 3'd2) && (data == KEY_EN);
  assign m_dis  = a_ok && (step == 3'd5) && (data == KEY_DIS);
  assign m_clr  = a_ok && (step == 3'd5) && (data == KEY_CLR);

  always_comb begin
    AST_ONE_MATCH: assert ($onehot0({m_cont, m_en, m_dis, m_clr})); // R7
  end
endmodule

// File: rtl/wprot_tmr.sv
module wprot_tmr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (en && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == LIM);
endmodule

// File: rtl/wprot_flag.sv
module wprot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic val,
  output logic prot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prot <= 1'b0;
    else if (upd) prot <= val;
  end
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 128,
  parameter int WIN_CYC    = 16,
  parameter int CLR_CYC    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              prog_done,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic              page_open,
  output logic              page_go,
  output logic              prot_on,
  output logic              clr_start,
  output logic              clr_busy,
  output logic              seq_abort,
  output logic              wr_reject
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int SEC_W = ADDR_W - PG_W;
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] PAGE_N = CNT_W'(PAGE_BYTES);

  seq_st_e          st_q, st_d;
  pend_e            pend_q, pend_d;
  logic [2:0]       step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEC_W-1:0] sec_q, sec_d, sec_sel;

  logic take, win_hit, clr_done;
  logic m_cont, m_en, m_dis, m_clr;
  logic we_d, go_d, ab_d, rj_d, cs_d;
  logic fl_upd, fl_val;

  wprot_match #(.ADDR_W(ADDR_W)) u_match (
    .step  (step_q),
    .addr  (ld_addr),
    .data  (ld_data),
    .m_cont(m_cont),
    .m_en  (m_en),
    .m_dis (m_dis),
    .m_clr (m_clr)
  );

  wprot_tmr #(.LIMIT(WIN_CYC)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (take || st_q == ST_IDLE),
    .en   (st_q == ST_SEQ || st_q == ST_PAGE),
    .hit  (win_hit)
  );

  wprot_tmr #(.LIMIT(CLR_CYC - 1)) u_clr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st_q != ST_CLR),
    .en   (1'b1),
    .hit  (clr_done)
  );

  wprot_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (fl_upd),
    .val  (fl_val),
    .prot (prot_on)
  );

  assign ld_ready  = (st_q == ST_IDLE) ||
                     ((st_q == ST_SEQ || st_q == ST_PAGE) && !win_hit);
  assign take      = ld_valid && ld_ready;
  assign page_open = (st_q == ST_PAGE);
  assign clr_busy  = (st_q == ST_CLR);
  assign sec_sel   = (st_q == ST_IDLE || cnt_q == '0) ? ld_addr[ADDR_W-1:PG_W] : sec_q;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    step_d = step_q;
    cnt_d  = cnt_q;
    sec_d  = sec_q;
    we_d   = 1'b0;
    go_d   = 1'b0;
    ab_d   = 1'b0;
    rj_d   = 1'b0;
    cs_d   = 1'b0;
    fl_upd = 1'b0;
    fl_val = 1'b0;
    case (st_q)
      ST_IDLE: if (take) begin
        if (m_cont) begin
          st_d   = ST_SEQ;
          step_d = 3'd1;
        end else if (prot_on) begin
          rj_d = 1'b1;
        end else begin
          st_d   = ST_PAGE;
          pend_d = PD_NONE;
          sec_d  = sec_sel;
          cnt_d  = CNT_W'(1);
          we_d   = 1'b1;
        end
      end
      ST_SEQ: begin
        if (win_hit) begin
          ab_d   = 1'b1;
          st_d   = ST_IDLE;
          step_d = 3'd0;
        end else if (take) begin
          if (m_cont) begin
            step_d = step_q + 3'd1;
          end else if (m_en || m_dis) begin
            st_d   = ST_PAGE;
            pend_d = m_en ? PD_EN : PD_DIS;
            cnt_d  = '0;
            step_d = 3'd0;
          end else if (m_clr) begin
            st_d   = ST_CLR;
            cs_d   = 1'b1;
            step_d = 3'd0;
          end else begin
            ab_d   = 1'b1;
            st_d   = ST_IDLE;
            step_d = 3'd0;
          end
        end
      end
      ST_PAGE: begin
        if (win_hit) begin
          if (pend_q == PD_NONE && cnt_q != '0) begin
            go_d = 1'b1;
            st_d = ST_PROG;
          end else begin
            ab_d   = 1'b1;
            st_d   = ST_IDLE;
            pend_d = PD_NONE;
          end
        end else if (take) begin
          we_d  = 1'b1;
          sec_d = sec_sel;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q + 1'b1 == PAGE_N) begin
            go_d = 1'b1;
            st_d = ST_PROG;
          end
        end
      end
      ST_PROG: if (prog_done) begin
        st_d = ST_IDLE;
        if (pend_q != PD_NONE) begin
          fl_upd = 1'b1;
          fl_val = (pend_q == PD_EN);
        end
        pend_d = PD_NONE;
      end
      ST_CLR: if (clr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= PD_NONE;
      step_q    <= 3'd0;
      cnt_q     <= '0;
      sec_q     <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      page_go   <= 1'b0;
      seq_abort <= 1'b0;
      wr_reject <= 1'b0;
      clr_start <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      step_q    <= step_d;
      cnt_q     <= cnt_d;
      sec_q     <= sec_d;
      buf_we    <= we_d;
      page_go   <= go_d;
      seq_abort <= ab_d;
      wr_reject <= rj_d;
      clr_start <= cs_d;
      if (we_d) begin
        buf_addr <= {sec_sel, ld_addr[PG_W-1:0]};
        buf_data <= ld_data;
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_abort, wr_reject, page_go, clr_start})); // R7
  AST_STORE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(ld_valid && ld_ready)); // R12
  AST_PROT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on != $past(prot_on)) |-> $past(prog_done)); // R5
  AST_REJECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> !buf_we && !page_open); // R6
  AST_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |-> clr_busy && !ld_ready); // R11
  AST_GO_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    page_go |-> !ld_ready); // R12
endmodule

// File: tb/tb_wprot_seq.sv
module tb_wprot_seq;
  localparam int AW   = 15;
  localparam int PG   = 128;
  localparam int WIN  = 16;
  localparam int CLRN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic prog_done = 1'b0;
  logic ld_ready, buf_we, page_open, page_go, prot_on, clr_start, clr_busy, seq_abort, wr_reject;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;

  int n_chk = 0, n_fail = 0;
  int n_we = 0, n_go = 0, n_ab = 0, n_rj = 0, n_cs = 0;
  logic [AW-1:0] last_a;
  logic [7:0] last_d;
  bit finished = 0;

  always #10 clk = ~clk;

  wprot_seq #(.ADDR_W(AW), .PAGE_BYTES(PG), .WIN_CYC(WIN), .CLR_CYC(CLRN)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .prog_done(prog_done),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .page_open(page_open), .page_go(page_go), .prot_on(prot_on),
    .clr_start(clr_start), .clr_busy(clr_busy), .seq_abort(seq_abort),
    .wr_reject(wr_reject)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (buf_we) begin n_we++; last_a = buf_addr; last_d = buf_data; end
      if (page_go) n_go++;
      if (seq_abort) n_ab++;
      if (wr_reject) n_rj++;
      if (clr_start) n_cs++;
    end
  end

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] first, logic [AW-1:0] cur);
    return {first[AW-1:7], cur[6:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(logic [AW-1:0] a, logic [7:0] d);
    ld_addr = a; ld_data = d; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd_en();
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, 8'hA0);
  endtask

  task automatic cmd_six(logic [7:0] last);
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, 8'h80);
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, last);
  endtask

  // loads n bytes in a permuted order; upper address bits vary after the first load
  task automatic page(int n, bit plain, string tag, output int errs);
    logic [AW-1:0] first, a;
    logic [7:0] d;
    int off;
    errs = 0;
    off = $urandom_range(0, PG - 1);
    first = AW'($urandom);
    for (int i = 0; i < n; i++) begin
      int we0;
      a = {(i == 0) ? first[AW-1:7] : 8'($urandom), 7'((i * 37 + off) % PG)};
      d = 8'($urandom);
      if (i == 0 && plain && d == 8'hAA) d = 8'h00;
      if (i == 0) first = a;
      we0 = n_we;
      put(a, d);
      if (n_we != we0 + 1 || last_a != exp_addr(first, a) || last_d != d) errs++;
    end
    check(errs == 0, tag, errs, 0);
  endtask

  task automatic end_prog();
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
  endtask

  initial begin
    int e, we0, go0, ab0, rj0, cs0, busy;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(prot_on == 0 && ld_ready == 1 && page_open == 0 && clr_busy == 0, "R1 idle outputs",
          {prot_on, ld_ready, page_open, clr_busy}, 4'b0100);
    check(n_we + n_go + n_ab + n_rj + n_cs == 0, "R1 no pulses", n_we + n_go + n_ab + n_rj + n_cs, 0);

    // R2 / R12 random plain pages
    for (int p = 0; p < 5; p++) begin
      go0 = n_go;
      page(PG, 1, "R2 plain page stores", e);
      check(n_go == go0 + 1, "R2 page_go after full page", n_go - go0, 1);
      we0 = n_we;
      ld_addr = 15'h0123; ld_data = 8'h5A; ld_valid = 1'b1;
      idle(3);
      check(ld_ready == 0 && n_we == we0, "R12 back-pressure while programming", ld_ready, 0);
      ld_valid = 1'b0;
      end_prog();
      check(prot_on == 0 && ld_ready == 1, "R2 flag stays off", prot_on, 0);
    end

    // R9 partial plain page then window expiry
    go0 = n_go; ab0 = n_ab;
    page(5, 1, "R9 partial stores", e);
    idle(WIN + 8);
    check(n_go == go0 + 1 && n_ab == ab0, "R9 partial page programs", n_go - go0, 1);
    end_prog();

    // R3 / R5 enable
    we0 = n_we;
    cmd_en();
    check(n_we == we0 && page_open == 1, "R3 command loads not stored", n_we - we0, 0);
    page(PG, 0, "R3 enable page stores", e);
    idle(2);
    check(prot_on == 0, "R5 flag unchanged before prog_done", prot_on, 0);
    end_prog();
    check(prot_on == 1, "R3 flag set after program end", prot_on, 1);

    // R6 protected write without prefix
    we0 = n_we; rj0 = n_rj;
    put(15'h1234, 8'h77);
    check(n_rj == rj0 + 1 && n_we == we0 && page_open == 0, "R6 unprefixed write rejected",
          n_rj - rj0, 1);
    go0 = n_go;
    cmd_en();
    page(PG, 0, "R6 prefixed page stores", e);
    check(n_go == go0 + 1, "R6 prefixed page programs", n_go - go0, 1);
    end_prog();
    check(prot_on == 1, "R6 flag stays on", prot_on, 1);

    // R7 mismatches
    ab0 = n_ab; we0 = n_we;
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, 8'h77);
    check(n_ab == ab0 + 1 && n_we == we0 && page_open == 0, "R7 wrong data aborts", n_ab - ab0, 1);
    ab0 = n_ab;
    put(15'h5555, 8'hAA); put(15'h2AAB, 8'h55);
    check(n_ab == ab0 + 1 && n_we == we0 && page_open == 0, "R7 wrong address aborts", n_ab - ab0, 1);
    ab0 = n_ab;
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, 8'h80);
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55); put(15'h5555, 8'h30);
    check(n_ab == ab0 + 1 && page_open == 0 && clr_busy == 0, "R7 wrong last byte aborts", n_ab - ab0, 1);

    // R8 window expiry inside a command
    ab0 = n_ab;
    put(15'h5555, 8'hAA); put(15'h2AAA, 8'h55);
    idle(WIN + 8);
    check(n_ab == ab0 + 1 && ld_ready == 1, "R8 command window expiry", n_ab - ab0, 1);

    // R10 enable then no data / partial data
    ab0 = n_ab; go0 = n_go;
    cmd_en();
    idle(WIN + 8);
    check(n_ab == ab0 + 1 && n_go == go0 && page_open == 0, "R10 enable with no data aborts", n_ab - ab0, 1);
    ab0 = n_ab;
    cmd_six(8'h20);
    page(10, 0, "R10 partial stores", e);
    idle(WIN + 8);
    check(n_ab == ab0 + 1 && n_go == go0 && prot_on == 1, "R10 partial disable aborts, flag kept",
          n_ab - ab0, 1);

    // R4 / R5 disable
    cmd_six(8'h20);
    page(PG, 0, "R4 disable page stores", e);
    idle(2);
    check(prot_on == 1, "R5 flag unchanged before prog_done", prot_on, 1);
    end_prog();
    check(prot_on == 0, "R4 flag cleared after program end", prot_on, 0);

    // R11 chip clear
    cs0 = n_cs; we0 = n_we;
    cmd_six(8'h10);
    check(n_cs == cs0 + 1 && clr_busy == 1 && ld_ready == 0, "R11 clear started", n_cs - cs0, 1);
    busy = 0;
    while (clr_busy && busy < 4 * CLRN) begin busy++; @(negedge clk); end
    check(busy == CLRN, "R11 clear busy cycles", busy, CLRN);
    check(prot_on == 0 && n_we == we0 && ld_ready == 1, "R11 flag and buffer untouched", prot_on, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule